// File: doc/BRIEF.md
# Firmware Image Loader

This block takes a coprocessor firmware image presented as a stream of 32-bit words and checks it on the fly. At the same time it copies the two program sections into their memories. The image is a five-word header, then an instruction section, then a data section, then one checksum word. The source of the stream also supplies the total image length in bytes. The block samples that length with the first word of each image.

The first word identifies the image and sets its byte order. If it is one of two mirror-image marker values, the block knows whether every later word must be byte-reversed. The block then checks the two section sizes against three rules: word alignment, the memory depth, and an exact length equation. If the sizes pass, each section word goes out on its own memory write port, addressed from word 0. A running 32-bit sum covers everything except the final word, and that final word must equal it.

The outcome is shown for one cycle on a `done` strobe. With it come a two-bit result code, the detected byte order, and the two segment fields of the header's sequence word. After a rejection the block makes no further memory writes. It keeps accepting and discarding words until the declared length has been consumed, so the next image starts on a clean boundary.

Top module: `fw_image_loader`

## Requirements
- R1: A first word of 0xfe0101fe selects little-endian order: every word is used as received, and a correct image ends with `err_code` 0 and `big_endian` 0.
- R2: A first word of 0xfe1010fe selects big-endian order: every later word, including the size words and the checksum, is byte-reversed before use. The section words are written reversed, and `big_endian` reads 1 at `done`.
- R3: Any other first word ends the image with `err_code` 1 and `big_endian` 0. No memory writes follow, and exactly floor(`img_len`/4) words are consumed before `done`.
- R4: An instruction or data size (header words 3 and 4, in bytes) that is not a multiple of 4 gives `err_code` 2 and no memory writes.
- R5: `img_len` must equal 24 plus both section sizes. This also covers a stream that ends before the five-word header is complete. Otherwise `err_code` is 2, there are no writes, and floor(`img_len`/4) words are consumed.
- R6: A section of more than DEPTH words gives `err_code` 2 and no writes. A section of exactly DEPTH words is accepted.
- R7: Section word k goes to address k of its own memory: first the instruction section on the `imem_*` port, then the data section on the `dmem_*` port. Each word is written once, only on an accepted input word, and never on both ports at once.
- R8: The checksum is the modulo-2^32 sum of the five converted header words and all converted section words. If the last word matches, `err_code` is 0; otherwise `err_code` is 3, and the section writes already made stand.
- R9: At `done`, `seg_total` and `seg_index` show bits [31:16] and [15:0] of the converted header word 1 of that image.
- R10: After reset, `done` is 0, `in_ready` is 1 and no write is issued. `done` rises for exactly one cycle, the cycle after the image's last word is accepted. During that cycle `in_ready` is 0. Cycles with `in_valid` low change nothing.
- R11: Sections of zero length are legal. An image of header plus checksum alone is verified with no writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is present |
| in_data | input | 32 | Raw image word |
| img_len | input | LEN_W | Total image length in bytes, sampled with the first word |
| in_ready | output | 1 | Block accepts a word this cycle |
| imem_we | output | 1 | Instruction memory write enable |
| imem_addr | output | AW | Instruction memory word address |
| imem_wdata | output | 32 | Instruction memory write data (converted) |
| dmem_we | output | 1 | Data memory write enable |
| dmem_addr | output | AW | Data memory word address |
| dmem_wdata | output | 32 | Data memory write data (converted) |
| done | output | 1 | One-cycle end-of-image strobe |
| err_code | output | 2 | 0 pass, 1 bad marker, 2 bad size, 3 bad checksum; valid with done |
| big_endian | output | 1 | Image was big-endian; valid with done |
| seg_total | output | 16 | Segment count from the sequence word |
| seg_index | output | 16 | Segment index from the sequence word |

## Verification
The bench builds the block with DEPTH = 8 and LEN_W = 12. The small depth makes the depth limit reachable with short images: a 9-word section must be refused and a pair of full 8-word sections must be accepted. A 12-bit length keeps the length arithmetic narrow while still exercising the exact length equation, including lengths that are not multiples of four. Images in both byte orders, and images with empty sections, run back to back, so the discarding of words after a rejection and the return to a clean image boundary are tested in sequence.

// File: rtl/fwld_pkg.sv
package fwld_pkg;

    localparam logic [31:0] MARK_LITTLE = 32'hfe0101fe;
    localparam logic [31:0] MARK_BIG    = 32'hfe1010fe;
    localparam int          HDR_WORDS   = 5;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_MAGIC = 2'd1,
        ERR_SIZE  = 2'd2,
        ERR_SUM   = 2'd3
    } err_e;

    typedef enum logic [2:0] {
        ST_HDR,
        ST_ISEC,
        ST_DSEC,
        ST_CSUM,
        ST_DRAIN,
        ST_REPORT
    } st_e;

    typedef struct packed {
        logic [15:0] total;
        logic [15:0] index;
    } seg_t;

    function automatic logic [31:0] swap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/fwld_conv.sv
module fwld_conv
    import fwld_pkg::*;
(
    input  logic [31:0] raw,
    input  logic        swap_en,
    output logic [31:0] word,
    output logic        mark_little,
    output logic        mark_big
);
    assign word        = swap_en ? swap32(raw) : raw;
    assign mark_little = (raw == MARK_LITTLE);
    assign mark_big    = (raw == MARK_BIG);
endmodule

// File: rtl/fwld_size_check.sv
module fwld_size_check #(
    parameter int DEPTH = 256,
    parameter int LEN_W = 32,
    parameter int AW    = 8
) (
    input  logic [31:0]      isize,
    input  logic [31:0]      dsize,
    input  logic [LEN_W-1:0] img_len,
    output logic             ok,
    output logic [AW:0]      iwords,
    output logic [AW:0]      dwords
);
    localparam int SUM_W = 34;

    logic             aligned;
    logic             fits;
    logic             len_match;
    logic [SUM_W-1:0] need;

    assign aligned   = (isize[1:0] == 2'b00) && (dsize[1:0] == 2'b00);
    assign fits      = (isize[31:2] <= 30'(DEPTH)) && (dsize[31:2] <= 30'(DEPTH));
    assign need      = {2'b00, isize} + {2'b00, dsize} + SUM_W'(24);
    assign len_match = (need == {{(SUM_W-LEN_W){1'b0}}, img_len});
    assign ok        = aligned && fits && len_match;
    assign iwords    = isize[AW+2:2];
    assign dwords    = dsize[AW+2:2];
endmodule

// File: rtl/fwld_sum_acc.sv
module fwld_sum_acc (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic        add,
    input  logic [31:0] value,
    output logic [31:0] sum
);
    always_ff @(posedge clk) begin
        if (rst)       sum <= '0;
        else if (load) sum <= value;
        else if (add)  sum <= sum + value;
    end
endmodule

// File: rtl/fw_image_loader.sv
module fw_image_loader
    import fwld_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int LEN_W = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [31:0]      in_data,
    input  logic [LEN_W-1:0] img_len,
    output logic             in_ready,
    output logic             imem_we,
    output logic [AW-1:0]    imem_addr,
    output logic [31:0]      imem_wdata,
    output logic             dmem_we,
    output logic [AW-1:0]    dmem_addr,
    output logic [31:0]      dmem_wdata,
    output logic             done,
    output logic [1:0]       err_code,
    output logic             big_endian,
    output logic [15:0]      seg_total,
    output logic [15:0]      seg_index
);
    st_e              st;
    err_e             err_q;
    seg_t             seg_q;
    logic [2:0]       hidx;
    logic [LEN_W-1:0] wcnt;
    logic [LEN_W-1:0] len_q;
    logic             be_q;
    logic [31:0]      isz_q;
    logic [AW:0]      iw_q;
    logic [AW:0]      dw_q;
    logic [AW:0]      sec_cnt;

    logic             acc;
    logic             first;
    logic             last;
    logic [LEN_W-1:0] len_cur;
    logic [LEN_W-1:0] nwords;
    logic [LEN_W:0]   wnext;
    logic [31:0]      word;
    logic             mk_little;
    logic             mk_big;
    logic             sz_ok;
    logic [AW:0]      sz_iw;
    logic [AW:0]      sz_dw;
    logic [31:0]      sum;

    assign in_ready = (st != ST_REPORT);
    assign acc      = in_valid && in_ready;
    assign first    = (st == ST_HDR) && (hidx == 3'd0);
    assign len_cur  = first ? img_len : len_q;
    assign nwords   = len_cur >> 2;
    assign wnext    = {1'b0, wcnt} + 1'b1;
    assign last     = (wnext >= {1'b0, nwords});

    fwld_conv u_conv (
        .raw         (in_data),
        .swap_en     (first ? mk_big : be_q),
        .word        (word),
        .mark_little (mk_little),
        .mark_big    (mk_big)
    );

    fwld_size_check #(.DEPTH(DEPTH), .LEN_W(LEN_W), .AW(AW)) u_size (
        .isize   (isz_q),
        .dsize   (word),
        .img_len (len_q),
        .ok      (sz_ok),
        .iwords  (sz_iw),
        .dwords  (sz_dw)
    );

    fwld_sum_acc u_sum (
        .clk   (clk),
        .rst   (rst),
        .load  (acc && first),
        .add   (acc && ((st == ST_HDR) || (st == ST_ISEC) || (st == ST_DSEC))),
        .value (word),
        .sum   (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_HDR;
            err_q   <= ERR_NONE;
            seg_q   <= '0;
            hidx    <= '0;
            wcnt    <= '0;
            len_q   <= '0;
            be_q    <= 1'b0;
            isz_q   <= '0;
            iw_q    <= '0;
            dw_q    <= '0;
            sec_cnt <= '0;
        end else if (st == ST_REPORT) begin
            st   <= ST_HDR;
            hidx <= '0;
            wcnt <= '0;
        end else if (acc) begin
            wcnt <= wcnt + 1'b1;
            unique case (st)
                ST_HDR: begin
                    hidx <= hidx + 3'd1;
                    if (hidx == 3'd0) begin
                        len_q <= img_len;
                        be_q  <= mk_big;
                        if (!mk_little && !mk_big) begin
                            err_q <= ERR_MAGIC;
                            st    <= last ? ST_REPORT : ST_DRAIN;
                        end else if (last) begin
                            err_q <= ERR_SIZE;
                            st    <= ST_REPORT;
                        end
                    end else if (hidx < 3'(HDR_WORDS - 1)) begin
                        if (hidx == 3'd1) seg_q <= word;
                        if (hidx == 3'd3) isz_q <= word;
                        if (last) begin
                            err_q <= ERR_SIZE;
                            st    <= ST_REPORT;
                        end
                    end else begin
                        sec_cnt <= '0;
                        iw_q    <= sz_iw;
                        dw_q    <= sz_dw;
                        if (!sz_ok) begin
                            err_q <= ERR_SIZE;
                            st    <= last ? ST_REPORT : ST_DRAIN;
                        end else if (sz_iw != '0) st <= ST_ISEC;
                        else if (sz_dw != '0)     st <= ST_DSEC;
                        else                      st <= ST_CSUM;
                    end
                end
                ST_ISEC: begin
                    sec_cnt <= sec_cnt + 1'b1;
                    if (sec_cnt + 1'b1 == iw_q) begin
                        sec_cnt <= '0;
                        st      <= (dw_q != '0) ? ST_DSEC : ST_CSUM;
                    end
                end
                ST_DSEC: begin
                    sec_cnt <= sec_cnt + 1'b1;
                    if (sec_cnt + 1'b1 == dw_q) st <= ST_CSUM;
                end
                ST_CSUM: begin
                    err_q <= (word == sum) ? ERR_NONE : ERR_SUM;
                    st    <= ST_REPORT;
                end
                ST_DRAIN: begin
                    if (last) st <= ST_REPORT;
                end
                default: ;
            endcase
        end
    end

    assign imem_we    = acc && (st == ST_ISEC);
    assign imem_addr  = sec_cnt[AW-1:0];
    assign imem_wdata = word;
    assign dmem_we    = acc && (st == ST_DSEC);
    assign dmem_addr  = sec_cnt[AW-1:0];
    assign dmem_wdata = word;
    assign done       = (st == ST_REPORT);
    assign err_code   = err_q;
    assign big_endian = be_q;
    assign seg_total  = seg_q.total;
    assign seg_index  = seg_q.index;

endmodule

// File: rtl/fwld_chk.sv
module fwld_chk #(
    parameter int DEPTH = 256,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic          imem_we,
    input logic [AW-1:0] imem_addr,
    input logic          dmem_we,
    input logic [AW-1:0] dmem_addr,
    input logic          done,
    input logic [1:0]    err_code,
    input logic          big_endian
);
    // R7
    write_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (imem_we || dmem_we) |-> (in_valid && in_ready));

    // R7
    single_port_chk: assert property (@(posedge clk) disable iff (rst)
        !(imem_we && dmem_we));

    // R7
    imem_step_chk: assert property (@(posedge clk) disable iff (rst)
        (imem_we && $past(imem_we)) |-> (imem_addr == $past(imem_addr) + 1'b1));

    // R7
    dmem_step_chk: assert property (@(posedge clk) disable iff (rst)
        (dmem_we && $past(dmem_we)) |-> (dmem_addr == $past(dmem_addr) + 1'b1));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    done_stall_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !in_ready);

    // R3
    bad_mark_order_chk: assert property (@(posedge clk) disable iff (rst)
        (done && err_code == 2'd1) |-> !big_endian);
endmodule

bind fw_image_loader fwld_chk #(.DEPTH(DEPTH)) u_fwld_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .imem_we    (imem_we),
    .imem_addr  (imem_addr),
    .dmem_we    (dmem_we),
    .dmem_addr  (dmem_addr),
    .done       (done),
    .err_code   (err_code),
    .big_endian (big_endian)
);

// File: tb/test_fw_image_loader.sv
module test_fw_image_loader;
    localparam int DEPTH = 8;
    localparam int LEN_W = 12;
    localparam int AW    = 3;

    // vector: {big, iwords[3:0], dwords[3:0], mode[2:0], exp_err[1:0]}
    // mode 0 good, 1 bad marker, 2 bad checksum, 3 misaligned size,
    // mode 4 length too long, 5 stream shorter than header
    localparam int NV = 13;
    localparam logic [13:0] VEC [NV] = '{
        {1'b0, 4'd3, 4'd2, 3'd0, 2'd0},
        {1'b1, 4'd4, 4'd3, 3'd0, 2'd0},
        {1'b0, 4'd0, 4'd0, 3'd0, 2'd0},
        {1'b1, 4'd0, 4'd2, 3'd0, 2'd0},
        {1'b0, 4'd8, 4'd8, 3'd0, 2'd0},
        {1'b0, 4'd2, 4'd2, 3'd1, 2'd1},
        {1'b1, 4'd2, 4'd1, 3'd2, 2'd3},
        {1'b0, 4'd2, 4'd2, 3'd3, 2'd2},
        {1'b1, 4'd1, 4'd1, 3'd4, 2'd2},
        {1'b0, 4'd0, 4'd0, 3'd5, 2'd2},
        {1'b0, 4'd9, 4'd1, 3'd0, 2'd2},
        {1'b1, 4'd1, 4'd9, 3'd0, 2'd2},
        {1'b0, 4'd3, 4'd3, 3'd2, 2'd3}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [31:0]      in_data = '0;
    logic [LEN_W-1:0] img_len = '0;
    logic             in_ready;
    logic             imem_we, dmem_we;
    logic [AW-1:0]    imem_addr, dmem_addr;
    logic [31:0]      imem_wdata, dmem_wdata;
    logic             done;
    logic [1:0]       err_code;
    logic             big_endian;
    logic [15:0]      seg_total, seg_index;

    int n_chk = 0;
    int n_fail = 0;
    int iwr = 0;
    int dwr = 0;
    logic [31:0] imem_m [16];
    logic [31:0] dmem_m [16];
    logic [31:0] img [32];

    always #5 clk = ~clk;

    fw_image_loader #(.DEPTH(DEPTH), .LEN_W(LEN_W)) i_fw_image_loader (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .img_len(img_len), .in_ready(in_ready),
        .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
        .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .done(done), .err_code(err_code), .big_endian(big_endian),
        .seg_total(seg_total), .seg_index(seg_index)
    );

    always @(posedge clk) begin
        if (imem_we) begin imem_m[imem_addr] <= imem_wdata; iwr <= iwr + 1; end
        if (dmem_we) begin dmem_m[dmem_addr] <= dmem_wdata; dwr <= dwr + 1; end
    end

    function automatic logic [31:0] swp(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] pat(input int s, input int k, input int v);
        return {8'(8'hC0 + v), 8'(s), 8'(k * 7 + 1), 8'hE3};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic send_word(input logic [31:0] w, input bit gap);
        if (gap) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        @(posedge clk);
    endtask

    task automatic run_vec(input int v);
        logic        be;
        int          iw, dw, mode, nw, len, isz;
        logic [1:0]  ex;
        logic [31:0] lw [32];
        logic [31:0] s;
        string       tag;
        int          bad;
        be   = VEC[v][13];
        iw   = int'(VEC[v][12:9]);
        dw   = int'(VEC[v][8:5]);
        mode = int'(VEC[v][4:2]);
        ex   = VEC[v][1:0];
        isz  = iw * 4 + ((mode == 3) ? 2 : 0);
        lw[0] = be ? 32'hfe1010fe : 32'hfe0101fe;
        lw[1] = {16'd5, 16'(v)};
        lw[2] = 32'h0003_0102 + 32'(v);
        lw[3] = 32'(isz);
        lw[4] = 32'(dw * 4);
        for (int k = 0; k < iw; k++) lw[5 + k] = pat(0, k, v);
        for (int k = 0; k < dw; k++) lw[5 + iw + k] = pat(1, k, v);
        s = '0;
        for (int k = 0; k < 5 + iw + dw; k++) s = s + lw[k];
        lw[5 + iw + dw] = (mode == 2) ? s + 32'd1 : s;
        nw  = 6 + iw + dw;
        len = nw * 4 + ((mode == 3) ? 2 : 0);
        if (mode == 4) begin lw[nw] = 32'h0; nw = nw + 1; len = nw * 4; end
        if (mode == 5) begin nw = 3; len = 12; end
        for (int k = 0; k < nw; k++) img[k] = be ? swp(lw[k]) : lw[k];
        if (mode == 1) img[0] = 32'h12345678;

        if (ex == 2'd1)                 tag = "R3";
        else if (mode == 3)             tag = "R4";
        else if (mode == 4 || mode == 5) tag = "R5";
        else if (iw > 8 || dw > 8)      tag = "R6";
        else if (ex == 2'd3)            tag = "R8";
        else if (iw == 0 && dw == 0)    tag = "R11";
        else if (be)                    tag = "R2";
        else                            tag = "R1";

        @(negedge clk);
        iwr = 0;
        dwr = 0;
        img_len = LEN_W'(len);
        for (int k = 0; k < nw; k++) send_word(img[k], be && (k % 3 == 2));
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10", "done after last word", 32'(done), 32'd1);
        chk(tag, "result code", 32'(err_code), 32'(ex));
        chk(tag, "byte order flag", 32'(big_endian), (mode == 1) ? 32'd0 : 32'(be));
        if (ex != 2'd1) begin
            chk("R9", "segment total", 32'(seg_total), 32'd5);
            chk("R9", "segment index", 32'(seg_index), 32'(v));
        end
        if (ex == 2'd0 || ex == 2'd3) begin
            chk("R7", "imem write count", 32'(iwr), 32'(iw));
            chk("R7", "dmem write count", 32'(dwr), 32'(dw));
            bad = 0;
            for (int k = 0; k < iw; k++) if (imem_m[k] !== pat(0, k, v)) bad++;
            for (int k = 0; k < dw; k++) if (dmem_m[k] !== pat(1, k, v)) bad++;
            chk(be ? "R2" : "R7", "section content mismatches", 32'(bad), 32'd0);
        end else begin
            chk(tag, "writes after rejection", 32'(iwr + dwr), 32'd0);
        end
        @(negedge clk);
        chk("R10", "done lasts one cycle", 32'(done), 32'd0);
        chk("R10", "ready after report", 32'(in_ready), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R10 watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk("R10", "done after reset", 32'(done), 32'd0);
        chk("R10", "ready after reset", 32'(in_ready), 32'd1);
        chk("R10", "no write after reset", 32'(imem_we | dmem_we), 32'd0);
        // R10: idle input changes nothing
        in_data = 32'hfe0101fe;
        repeat (5) @(negedge clk);
        chk("R10", "idle done", 32'(done), 32'd0);
        chk("R10", "idle writes", 32'(iwr + dwr), 32'd0);

        for (int v = 0; v < NV; v++) run_vec(v);

        // R10: reset in the middle of an image, then a clean image
        img_len = 12'd36;
        send_word(32'hfe0101fe, 1'b0);
        send_word(32'h0005_0000, 1'b0);
        send_word(32'h1, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "ready after mid-image reset", 32'(in_ready), 32'd1);
        run_vec(0);
        run_vec(1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule